// File: doc/BRIEF.md
# Q15 FIR Low-Pass Filter with Saturating Output

This block is a short fixed-point FIR low-pass filter. It works on signed 16-bit samples in Q15 format. Each accepted sample is multiplied against a fixed set of integer Q15 coefficients. The coefficients are parameters, obtained by rounding the real tap weights times 2^15. The products are summed at full precision in a 32-bit Q30 accumulator. The sum is then narrowed back to Q15 into a registered output.

A run-time input, `sat_en_i`, selects how the accumulator is narrowed. In saturating mode the output clamps to the Q15 limits when the Q30 sum falls outside the Q15 range. In wrap mode the output is a plain slice of the sum.

A parameter selects either a direct-form structure or a transposed structure. The two give identical results; the transposed form trades the adder chain for a chain of accumulator registers. A second parameter inverts the polarity of every incoming sample, and the most negative input maps to the most positive value.

The filter advances by exactly one sample per strobe, typically at an audio rate such as 48 kHz.

Top module: `q15_fir`

## Requirements
- R1: While `rst_ni` is low, the output and every internal delay or accumulator stage are held at zero, and the output reads 16'h0000 after reset is released.
- R2: With default parameters (three taps, coefficients 9830, 19661, 9830, i.e. 0.3, 0.6, 0.3 in Q15), the Q30 sum is S = 9830*x[n] + 19661*x[n-1] + 9830*x[n-2]. It is formed in 32-bit two's complement. The narrowed S is loaded into `smp_o` at the clock edge where `smp_vld_i` is high for x[n], and is visible after that edge.
- R3: In saturating mode (`sat_en_i`=1), a sum with bits [31:30] equal to 2'b01 (S >= 2^30) gives 16'h7FFF.
- R4: In saturating mode, a sum with bits [31:30] equal to 2'b10 (S < -2^30) gives 16'h8000.
- R5: When bits [31:30] agree, or whenever `sat_en_i`=0 (wrap mode), the output is bits [30:15] of the sum, i.e. floor(S / 2^15) taken modulo 2^16.
- R6: On a clock edge with `smp_vld_i` low, neither the output nor the stored sample history changes, whatever `smp_i` carries.
- R7: With `TRANSPOSED`=1, the output sequence is bit-identical to the direct form for the same input sequence and mode.
- R8: With `INVERT_IN`=1, each sample is negated before filtering, and an input of 16'h8000 is treated as 16'h7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe; one sample accepted per high cycle |
| sat_en_i | input | 1 | 1 = saturating narrowing, 0 = wrap-around slice |
| smp_i | input | 16 | Input sample, signed Q15 |
| smp_o | output | 16 | Filtered output sample, signed Q15, registered |

## Verification
The embedded properties assume that `smp_vld_i` and `sat_en_i` are known, non-X values on every clock edge after reset. They also assume that the mode is sampled on the same edge as the strobe it applies to. The stimulus respects this: it drives all inputs on the falling clock edge, holds them through the rising edge, and never leaves them undriven after reset. The properties compare the registered output against the accumulator value of the preceding accepted sample, and take no position on what the output shows between strobes other than that it holds.

// File: rtl/q15_fir_pkg.sv
package q15_fir_pkg;
  localparam int unsigned SMP_W = 16;
  localparam int unsigned ACC_W = 2 * SMP_W;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  localparam smp_t SMP_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam smp_t SMP_MIN = {1'b1, {(SMP_W-1){1'b0}}};
endpackage

// File: rtl/q15_polarity.sv
module q15_polarity
  import q15_fir_pkg::*;
#(
  parameter bit INVERT = 1'b0
) (
  input  smp_t x_i,
  output smp_t x_o
);
  if (INVERT) begin : g_inv
    // most negative value has no positive twin; clamp it
    assign x_o = (x_i == SMP_MIN) ? SMP_MAX : -x_i;

    always_comb begin
      p_no_min_out_r8: assert (x_o != SMP_MIN);
    end
  end else begin : g_pass
    assign x_o = x_i;
  end
endmodule

// File: rtl/q15_fir_direct.sv
module q15_fir_direct
  import q15_fir_pkg::*;
#(
  parameter int unsigned          NTAPS = 3,
  parameter logic [NTAPS*SMP_W-1:0] COEFS = {16'sd9830, 16'sd19661, 16'sd9830}
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  smp_t x_i,
  output acc_t acc_o
);
  localparam int unsigned NDLY = NTAPS - 1;

  smp_t dly_q [NDLY];
  acc_t prod  [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    localparam smp_t C = smp_t'(COEFS[k*SMP_W +: SMP_W]);
    if (k == 0) begin : g_cur
      assign prod[k] = acc_t'(x_i) * acc_t'(C);
    end else begin : g_old
      assign prod[k] = acc_t'(dly_q[k-1]) * acc_t'(C);
    end
  end

  // adder chain: depth grows with NTAPS
  always_comb begin
    acc_o = prod[0];
    for (int k = 1; k < NTAPS; k++) acc_o = acc_o + prod[k];
  end

  for (genvar k = 0; k < NDLY; k++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   dly_q[k] <= '0;
      else if (en_i) dly_q[k] <= (k == 0) ? x_i : dly_q[(k == 0) ? 0 : k-1];
    end
  end

  p_hold_dly_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dly_q[0]));
endmodule

// File: rtl/q15_fir_transposed.sv
module q15_fir_transposed
  import q15_fir_pkg::*;
#(
  parameter int unsigned          NTAPS = 3,
  parameter logic [NTAPS*SMP_W-1:0] COEFS = {16'sd9830, 16'sd19661, 16'sd9830}
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  smp_t x_i,
  output acc_t acc_o
);
  localparam int unsigned NST = NTAPS - 1;

  acc_t st_q [NST];
  acc_t prod [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    localparam smp_t C = smp_t'(COEFS[k*SMP_W +: SMP_W]);
    assign prod[k] = acc_t'(x_i) * acc_t'(C);
  end

  assign acc_o = prod[0] + st_q[0];

  // partial sums advance one register per sample; one adder per stage
  for (genvar k = 0; k < NST; k++) begin : g_st
    acc_t nxt;
    if (k == NST - 1) begin : g_tail
      assign nxt = prod[k+1];
    end else begin : g_mid
      assign nxt = prod[k+1] + st_q[k+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   st_q[k] <= '0;
      else if (en_i) st_q[k] <= nxt;
    end
  end

  p_hold_st_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(st_q[0]));
endmodule

// File: rtl/q15_narrow.sv
module q15_narrow
  import q15_fir_pkg::*;
(
  input  acc_t acc_i,
  input  logic sat_i,
  output smp_t q_o
);
  smp_t wrap_q;
  logic ovf_hi, ovf_lo;

  // Q30 -> Q15: drop 15 fraction bits, keep 16
  assign wrap_q = smp_t'(acc_i >>> (SMP_W - 1));
  assign ovf_hi = (acc_i[ACC_W-1 -: 2] == 2'b01);
  assign ovf_lo = (acc_i[ACC_W-1 -: 2] == 2'b10);

  always_comb begin
    q_o = wrap_q;
    if (sat_i && ovf_hi) q_o = SMP_MAX;
    if (sat_i && ovf_lo) q_o = SMP_MIN;
  end
endmodule

// File: rtl/q15_fir.sv
module q15_fir
  import q15_fir_pkg::*;
#(
  parameter int unsigned            NTAPS      = 3,
  parameter logic [NTAPS*SMP_W-1:0] COEFS      = {16'sd9830, 16'sd19661, 16'sd9830},
  parameter bit                     TRANSPOSED = 1'b0,
  parameter bit                     INVERT_IN  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic              sat_en_i,
  input  logic [SMP_W-1:0]  smp_i,
  output logic [SMP_W-1:0]  smp_o
);
  localparam acc_t Q30_HI = acc_t'(1) <<< (ACC_W - 2);

  smp_t x_pol;
  acc_t acc;
  smp_t q_nxt;
  smp_t y_q;

  q15_polarity #(.INVERT(INVERT_IN)) u_pol (
    .x_i (smp_t'(smp_i)),
    .x_o (x_pol)
  );

  if (TRANSPOSED) begin : g_tr
    q15_fir_transposed #(.NTAPS(NTAPS), .COEFS(COEFS)) u_core (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (smp_vld_i),
      .x_i   (x_pol),
      .acc_o (acc)
    );
  end else begin : g_df
    q15_fir_direct #(.NTAPS(NTAPS), .COEFS(COEFS)) u_core (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (smp_vld_i),
      .x_i   (x_pol),
      .acc_o (acc)
    );
  end

  q15_narrow u_narrow (
    .acc_i (acc),
    .sat_i (sat_en_i),
    .q_o   (q_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        y_q <= '0;
    else if (smp_vld_i) y_q <= q_nxt;
  end

  assign smp_o = y_q;

  p_hold_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> $stable(smp_o));

  p_sat_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && sat_en_i && acc >= Q30_HI) |=> smp_o == SMP_MAX);

  p_sat_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && sat_en_i && acc < -Q30_HI) |=> smp_o == SMP_MIN);

  p_slice_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && (!sat_en_i || acc[ACC_W-1] == acc[ACC_W-2]))
      |=> smp_o == $past(acc[ACC_W-2 -: SMP_W]));
endmodule

// File: tb/tb_q15_fir.sv
module tb_q15_fir;
  localparam int C0 = 9830, C1 = 19661, C2 = 9830;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_vld_i = 1'b0;
  logic sat_en_i = 1'b1;
  logic [15:0] smp_i = '0;
  logic [15:0] y_df, y_tr, y_inv;

  int n_chk = 0, n_bad = 0;
  int h1 = 0, h2 = 0, g1 = 0, g2 = 0;
  logic [15:0] exp_y = '0, exp_inv = '0;

  always #10 clk_i = ~clk_i;

  q15_fir dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i),
    .sat_en_i(sat_en_i), .smp_i(smp_i), .smp_o(y_df));

  q15_fir #(.TRANSPOSED(1'b1)) dut_tr (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i),
    .sat_en_i(sat_en_i), .smp_i(smp_i), .smp_o(y_tr));

  q15_fir #(.INVERT_IN(1'b1)) dut_inv (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i),
    .sat_en_i(sat_en_i), .smp_i(smp_i), .smp_o(y_inv));

  function automatic logic [15:0] ref_out(int x0, int x1, int x2, bit sat);
    longint s;
    logic signed [31:0] w;
    longint fl;
    s = longint'(C0) * x0 + longint'(C1) * x1 + longint'(C2) * x2;
    w = s[31:0];
    if (sat && w >= 32'sd1073741824) return 16'h7fff;
    if (sat && w < -32'sd1073741824) return 16'h8000;
    fl = longint'(w) >>> 15;
    return fl[15:0];
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs set at negedge; compare at following negedge
  task automatic step(bit vld, logic [15:0] x, bit sat, string tag);
    int xs, xi;
    smp_vld_i = vld;
    smp_i = x;
    sat_en_i = sat;
    if (vld) begin
      xs = int'($signed(x));
      xi = (xs == -32768) ? 32767 : -xs;
      exp_y = ref_out(xs, h1, h2, sat);
      exp_inv = ref_out(xi, g1, g2, sat);
      h2 = h1; h1 = xs;
      g2 = g1; g1 = xi;
    end
    @(negedge clk_i);
    check(tag, y_df, exp_y);
    check({tag, "/R7"}, y_tr, exp_y);
    check({tag, "/R8"}, y_inv, exp_inv);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", y_df, 16'h0000);
    check("R1", y_tr, 16'h0000);
    check("R1", y_inv, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", y_df, 16'h0000);

    // R2 impulse: -1.0 in, output walks the coefficients
    step(1, 16'h8000, 1, "R2_imp");
    step(1, 16'h0000, 1, "R2_imp");
    step(1, 16'h0000, 1, "R2_imp");
    step(1, 16'h0000, 1, "R2_imp");

    // R6 strobe low: garbage on input must not enter
    step(1, 16'h1234, 1, "R2");
    for (int i = 0; i < 6; i++) step(0, 16'(i * 16'h1357 + 16'h7001), 1, "R6_hold");
    step(1, 16'h0000, 1, "R6_hist");
    step(1, 16'h0000, 1, "R6_hist");

    // R3 positive full-scale step
    for (int i = 0; i < 5; i++) step(1, 16'h7fff, 1, "R3_step");
    // R4 negative full-scale step
    for (int i = 0; i < 5; i++) step(1, 16'h8000, 1, "R4_step");
    // R5 wrap mode with the same steps
    for (int i = 0; i < 5; i++) step(1, 16'h7fff, 0, "R5_wrap");
    for (int i = 0; i < 5; i++) step(1, 16'h8000, 0, "R5_wrap");
    // R8 alternating extremes through inverted path
    for (int i = 0; i < 4; i++) step(1, (i % 2) ? 16'h7fff : 16'h8000, 1, "R8_alt");

    // R2/R5 mixed random traffic, both modes, sparse strobes
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, 16'($urandom), ($urandom % 2) == 1, "R2_rand");

    finish_run();
  end
endmodule